// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block is the acknowledge path of a CPU interrupt interface. It keeps a small bank of list entries. Each entry is a 64-bit word holding a two-bit state, a group bit, an 8-bit priority and a virtual interrupt ID. When the CPU acknowledges an interrupt of a given group, the block scans the entries in use and picks the best pending one among the enabled groups. It then rejects that winner as spurious if its group does not match the request, if the priority mask does not admit it, or if it cannot preempt the running priority.

A winner that passes every check moves out of the pending state and its ID is returned. The block also raises a set-active strobe that carries the winner's priority and the requested group, for the tracker that maintains the running priority. A rejected acknowledge returns the spurious ID 1023 and changes nothing. Entries are written through a plain load port and can be read back through a combinational read port.

Top module: `iaa_ack_unit`

## Requirements
- R1: After reset, `ack_valid` and `setact_valid` are low and every entry word reads as zero, so every state field is idle.
- R2: An entry is a candidate only if its index is below `used_cnt` and its state field (bits 63:62) is exactly 01 (pending). The codes 00 (idle), 10 (active) and 11 (pending and active) are skipped.
- R3: A group-0 entry (bit 60 clear) is skipped while `en_grp0` is low. A group-1 entry (bit 60 set) is skipped while `en_grp1` is low.
- R4: The winner is the candidate with the numerically lowest priority (bits 55:48). When priorities tie, the lowest entry index wins.
- R5: If the winner's group differs from `ack_grp`, the result is spurious. Candidates of the requested group with lower priority are not tried instead.
- R6: The result is spurious unless `pmr` is strictly greater than the winner's priority.
- R7: The result is spurious unless `run_prio` is strictly greater than the winner's priority.
- R8: On success, `ack_id` returns the winner's ID (bits ID_W-1:0). The winner's state becomes 10 if its ID is at most 1019 and 00 otherwise.
- R9: `setact_valid` pulses with `setact_prio` equal to the winner's priority and `setact_grp` equal to `ack_grp`, and only on a successful acknowledge.
- R10: `ack_valid` is high exactly in the cycle after a cycle with `ack_req` high. The entry update takes effect at that same clock edge.
- R11: If a load and an acknowledge happen in the same cycle, the scan uses the old entry contents. If both touch the same entry, the loaded word is what remains in it.
- R12: A spurious acknowledge returns ID 1023 and leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write `ld_word` into entry `ld_idx` |
| ld_idx | input | IDX_W | Entry index for the load |
| ld_word | input | 64 | Entry word to load |
| rd_idx | input | IDX_W | Entry index for read-back |
| rd_word | output | 64 | Current contents of entry `rd_idx` |
| used_cnt | input | CNT_W | Number of entries in use, counted from index 0 |
| en_grp0 | input | 1 | Group-0 enable |
| en_grp1 | input | 1 | Group-1 enable |
| pmr | input | 8 | Priority mask |
| run_prio | input | 8 | Current highest active priority |
| ack_req | input | 1 | Acknowledge request strobe |
| ack_grp | input | 1 | Group of the acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | ID_W | Acknowledged ID, or 1023 if spurious |
| setact_valid | output | 1 | Set-active strobe |
| setact_prio | output | 8 | Priority to mark as active |
| setact_grp | output | 1 | Group to mark as active |

## Verification
An entry load and an acknowledge can land in the same cycle, and they can target the same entry. The bench provokes this by asserting `ld_en` and `ack_req` on one clock edge, both aimed at the current winner. It then checks two things: the returned ID belongs to the pre-load contents, and a read-back of that entry shows the newly loaded pending word rather than the active state the acknowledge would have written. A second acknowledge then has to return the loaded entry's ID.

// File: rtl/iaa_pkg.sv
package iaa_pkg;
  localparam int ENT_W      = 64;
  localparam int PRIO_W     = 8;
  localparam int ST_MSB     = 63;
  localparam int ST_LSB     = 62;
  localparam int GRP_BIT    = 60;
  localparam int PRIO_MSB   = 55;
  localparam int PRIO_LSB   = 48;
  localparam int MAX_SPI    = 1019;
  localparam int SPUR_ID    = 1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_PENDACT = 2'b11
  } ent_state_e;
endpackage

// File: rtl/iaa_entry_bank.sv
module iaa_entry_bank
  import iaa_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [IDX_W-1:0]            ld_idx,
  input  logic [ENT_W-1:0]            ld_word,
  input  logic                        upd_en,
  input  logic [IDX_W-1:0]            upd_idx,
  input  ent_state_e                  upd_state,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [ENT_W-1:0]            rd_word,
  output logic [N_ENT-1:0][ENT_W-1:0] ent_o
);

  logic [N_ENT-1:0][ENT_W-1:0] ent_q;
  logic [N_ENT-1:0][ENT_W-1:0] ent_d;
  logic [N_ENT-1:0]            ent_we;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    // next state: a load overrides a same-cycle acknowledge update
    always_comb begin
      ent_d[gi]  = ent_q[gi];
      ent_we[gi] = 1'b0;
      if (upd_en && (upd_idx == IDX_W'(gi))) begin
        ent_d[gi][ST_MSB:ST_LSB] = upd_state;
        ent_we[gi] = 1'b1;
      end
      if (ld_en && (ld_idx == IDX_W'(gi))) begin
        ent_d[gi]  = ld_word;
        ent_we[gi] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[gi] <= '0;
      end else if (ent_we[gi]) begin
        ent_q[gi] <= ent_d[gi];
      end
    end
  end

  assign ent_o   = ent_q;
  assign rd_word = ent_q[rd_idx];

endmodule

// File: rtl/iaa_select.sv
module iaa_select
  import iaa_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic [N_ENT-1:0][ENT_W-1:0] ent_i,
  input  logic [CNT_W-1:0]            used_cnt,
  input  logic                        en_grp0,
  input  logic                        en_grp1,
  output logic                        found,
  output logic [IDX_W-1:0]            win_idx,
  output logic [ENT_W-1:0]            win_word
);

  logic [PRIO_W-1:0] best;
  logic              cand;
  logic              grp;

  always_comb begin
    best     = IDLE_PRIO;
    found    = 1'b0;
    win_idx  = '0;
    win_word = '0;
    for (int i = 0; i < N_ENT; i++) begin
      grp  = ent_i[i][GRP_BIT];
      cand = (CNT_W'(i) < used_cnt)
          && (ent_i[i][ST_MSB:ST_LSB] == ST_PEND)
          && (grp ? en_grp1 : en_grp0);
      // strict compare keeps the lowest index on a tie
      if (cand && (ent_i[i][PRIO_MSB:PRIO_LSB] < best)) begin
        best     = ent_i[i][PRIO_MSB:PRIO_LSB];
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_word = ent_i[i];
      end
    end
  end

endmodule

// File: rtl/iaa_gate.sv
module iaa_gate
  import iaa_pkg::*;
#(
  parameter int ID_W = 24
) (
  input  logic              found,
  input  logic              win_grp,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [ID_W-1:0]   win_id,
  input  logic              ack_grp,
  input  logic [PRIO_W-1:0] pmr,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              pass,
  output ent_state_e        new_state
);

  always_comb begin
    pass = found
        && (win_grp == ack_grp)
        && (pmr > win_prio)
        && (run_prio > win_prio);
    new_state = (win_id <= ID_W'(MAX_SPI)) ? ST_ACT : ST_IDLE;
  end

endmodule

// File: rtl/iaa_ack_unit.sv
module iaa_ack_unit
  import iaa_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int ID_W  = 24,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [63:0]       ld_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [63:0]       rd_word,
  input  logic [CNT_W-1:0]  used_cnt,
  input  logic              en_grp0,
  input  logic              en_grp1,
  input  logic [7:0]        pmr,
  input  logic [7:0]        run_prio,
  input  logic              ack_req,
  input  logic              ack_grp,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              setact_valid,
  output logic [7:0]        setact_prio,
  output logic              setact_grp
);

  logic [N_ENT-1:0][ENT_W-1:0] ent;
  logic                        found;
  logic [IDX_W-1:0]            win_idx;
  logic [ENT_W-1:0]            win_word;
  logic                        pass;
  ent_state_e                  new_state;
  logic                        upd_en;

  iaa_entry_bank #(.N_ENT(N_ENT)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_word  (ld_word),
    .upd_en   (upd_en),
    .upd_idx  (win_idx),
    .upd_state(new_state),
    .rd_idx   (rd_idx),
    .rd_word  (rd_word),
    .ent_o    (ent)
  );

  iaa_select #(.N_ENT(N_ENT)) sel_i (
    .ent_i   (ent),
    .used_cnt(used_cnt),
    .en_grp0 (en_grp0),
    .en_grp1 (en_grp1),
    .found   (found),
    .win_idx (win_idx),
    .win_word(win_word)
  );

  iaa_gate #(.ID_W(ID_W)) gate_i (
    .found    (found),
    .win_grp  (win_word[GRP_BIT]),
    .win_prio (win_word[PRIO_MSB:PRIO_LSB]),
    .win_id   (win_word[ID_W-1:0]),
    .ack_grp  (ack_grp),
    .pmr      (pmr),
    .run_prio (run_prio),
    .pass     (pass),
    .new_state(new_state)
  );

  assign upd_en = ack_req && pass;

  // result registers: next state
  logic            ack_valid_d, setact_valid_d;
  logic [ID_W-1:0] ack_id_d;
  logic            res_en, sa_en;

  always_comb begin
    ack_valid_d    = ack_req;
    setact_valid_d = upd_en;
    res_en         = ack_req;
    sa_en          = upd_en;
    ack_id_d       = pass ? win_word[ID_W-1:0] : ID_W'(SPUR_ID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid    <= 1'b0;
      setact_valid <= 1'b0;
    end else begin
      ack_valid    <= ack_valid_d;
      setact_valid <= setact_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_id <= '0;
    end else if (res_en) begin
      ack_id <= ack_id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setact_prio <= '0;
      setact_grp  <= 1'b0;
    end else if (sa_en) begin
      setact_prio <= win_word[PRIO_MSB:PRIO_LSB];
      setact_grp  <= ack_grp;
    end
  end

endmodule

// File: rtl/iaa_ack_unit_chk.sv
module iaa_ack_unit_chk #(
  parameter int ID_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_req,
  input logic            ack_grp,
  input logic [7:0]      pmr,
  input logic [7:0]      run_prio,
  input logic            ack_valid,
  input logic [ID_W-1:0] ack_id,
  input logic            setact_valid,
  input logic [7:0]      setact_prio,
  input logic            setact_grp
);

  assert_ack_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  assert_no_ack_without_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);

  assert_setact_only_on_success_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setact_valid |-> (ack_valid && (ack_id != ID_W'(1023))));

  assert_setact_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (setact_valid -> (setact_grp == $past(ack_grp))));

  assert_mask_admits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (setact_valid -> (setact_prio < $past(pmr))));

  assert_preempts_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (setact_valid -> (setact_prio < $past(run_prio))));

endmodule

bind iaa_ack_unit iaa_ack_unit_chk #(.ID_W(ID_W)) chk_i (.*);

// File: tb/iaa_ack_unit_tb_top.sv
module iaa_ack_unit_tb_top;
  localparam int N_ENT = 16;
  localparam int ID_W  = 24;
  localparam int IDX_W = $clog2(N_ENT);
  localparam int CNT_W = $clog2(N_ENT + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_en;
  logic [IDX_W-1:0]  ld_idx;
  logic [63:0]       ld_word;
  logic [IDX_W-1:0]  rd_idx;
  logic [63:0]       rd_word;
  logic [CNT_W-1:0]  used_cnt;
  logic              en_grp0, en_grp1;
  logic [7:0]        pmr, run_prio;
  logic              ack_req, ack_grp;
  logic              ack_valid;
  logic [ID_W-1:0]   ack_id;
  logic              setact_valid;
  logic [7:0]        setact_prio;
  logic              setact_grp;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  iaa_ack_unit #(.N_ENT(N_ENT), .ID_W(ID_W)) dut_i (.*);

  function automatic logic [63:0] mkw(logic [1:0] st, logic g, logic [7:0] p, logic [23:0] id);
    logic [63:0] w;
    w = '0;
    w[63:62] = st;
    w[60]    = g;
    w[55:48] = p;
    w[23:0]  = id;
    return w;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int idx, logic [63:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IDX_W'(idx); ld_word = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N_ENT; i++) load(i, 64'd0);
  endtask

  task automatic ack(logic g);
    @(negedge clk);
    ack_req = 1'b1; ack_grp = g;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  function automatic logic [1:0] st_of(int idx);
    return 2'b00;
  endfunction

  task automatic rd_state(int idx, output logic [1:0] st);
    rd_idx = IDX_W'(idx);
    #1;
    st = rd_word[63:62];
  endtask

  task automatic t_reset();
    logic [1:0] st;
    check("R1", "ack_valid", ack_valid, 0);
    check("R1", "setact_valid", setact_valid, 0);
    rd_idx = '0; #1;
    check("R1", "entry0 word", rd_word, 0);
    rd_idx = IDX_W'(N_ENT-1); #1;
    check("R1", "last entry word", rd_word, 0);
    rd_state(3, st);
    check("R1", "entry3 state", st, 0);
  endtask

  task automatic t_pick();
    logic [1:0] st;
    clear_all();
    load(2, mkw(2'b01, 1'b1, 8'd40, 24'd100));
    load(5, mkw(2'b01, 1'b1, 8'd20, 24'd200));
    load(7, mkw(2'b01, 1'b1, 8'd20, 24'd300));
    ack(1'b1);
    check("R4", "tie lowest index id", ack_id, 200);
    check("R9", "setact_valid", setact_valid, 1);
    check("R9", "setact_prio", setact_prio, 20);
    check("R9", "setact_grp", setact_grp, 1);
    rd_state(5, st);
    check("R8", "entry5 active", st, 2'b10);
    ack(1'b1);
    check("R4", "second id", ack_id, 300);
    ack(1'b1);
    check("R4", "third id", ack_id, 100);
    ack(1'b1);
    check("R2", "none pending spurious", ack_id, 1023);
  endtask

  task automatic t_state();
    clear_all();
    load(0, mkw(2'b10, 1'b1, 8'd5, 24'd11));
    load(1, mkw(2'b11, 1'b1, 8'd6, 24'd22));
    load(3, mkw(2'b01, 1'b1, 8'd30, 24'd33));
    load(4, mkw(2'b01, 1'b1, 8'd1, 24'd44));
    used_cnt = CNT_W'(4);
    ack(1'b1);
    check("R2", "active/used_cnt skipped", ack_id, 33);
    used_cnt = CNT_W'(N_ENT);
    ack(1'b1);
    check("R2", "entry4 after widening", ack_id, 44);
  endtask

  task automatic t_group();
    logic [1:0] st;
    clear_all();
    load(0, mkw(2'b01, 1'b0, 8'd10, 24'd50));
    load(1, mkw(2'b01, 1'b1, 8'd60, 24'd61));
    en_grp0 = 1'b0;
    ack(1'b1);
    check("R3", "grp0 disabled, grp1 wins", ack_id, 61);
    en_grp0 = 1'b1;
    load(1, mkw(2'b01, 1'b1, 8'd60, 24'd61));
    ack(1'b1);
    check("R5", "group mismatch spurious", ack_id, 1023);
    check("R9", "no setact on spurious", setact_valid, 0);
    rd_state(0, st);
    check("R12", "entry0 untouched", st, 2'b01);
    rd_state(1, st);
    check("R12", "entry1 untouched", st, 2'b01);
    en_grp1 = 1'b0;
    ack(1'b0);
    check("R3", "grp1 disabled, grp0 wins", ack_id, 50);
    en_grp1 = 1'b1;
  endtask

  task automatic t_pmr();
    clear_all();
    load(0, mkw(2'b01, 1'b1, 8'h40, 24'd70));
    pmr = 8'h40;
    ack(1'b1);
    check("R6", "pmr equal spurious", ack_id, 1023);
    pmr = 8'h41;
    ack(1'b1);
    check("R6", "pmr above passes", ack_id, 70);
    pmr = 8'hFF;
  endtask

  task automatic t_run();
    clear_all();
    load(0, mkw(2'b01, 1'b1, 8'h30, 24'd80));
    run_prio = 8'h30;
    ack(1'b1);
    check("R7", "running equal spurious", ack_id, 1023);
    run_prio = 8'h31;
    ack(1'b1);
    check("R7", "running above passes", ack_id, 80);
    run_prio = 8'hFF;
  endtask

  task automatic t_lpi();
    logic [1:0] st;
    clear_all();
    load(0, mkw(2'b01, 1'b1, 8'd5, 24'd8192));
    load(1, mkw(2'b01, 1'b1, 8'd6, 24'd1019));
    load(2, mkw(2'b01, 1'b1, 8'd7, 24'd1020));
    ack(1'b1);
    check("R8", "large id returned", ack_id, 8192);
    rd_state(0, st);
    check("R8", "large id idle", st, 2'b00);
    ack(1'b1);
    rd_state(1, st);
    check("R8", "id 1019 active", st, 2'b10);
    ack(1'b1);
    check("R8", "id 1020 returned", ack_id, 1020);
    rd_state(2, st);
    check("R8", "id 1020 idle", st, 2'b00);
  endtask

  task automatic t_latency();
    clear_all();
    load(0, mkw(2'b01, 1'b1, 8'd9, 24'd77));
    @(negedge clk);
    ack_req = 1'b1; ack_grp = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    check("R10", "valid one cycle later", ack_valid, 1);
    check("R10", "id", ack_id, 77);
    @(negedge clk);
    check("R10", "valid drops", ack_valid, 0);
  endtask

  task automatic t_collide();
    logic [1:0] st;
    clear_all();
    load(0, mkw(2'b01, 1'b1, 8'd10, 24'd90));
    @(negedge clk);
    ack_req = 1'b1; ack_grp = 1'b1;
    ld_en = 1'b1; ld_idx = '0; ld_word = mkw(2'b01, 1'b1, 8'd20, 24'd91);
    @(negedge clk);
    ack_req = 1'b0; ld_en = 1'b0;
    check("R11", "ack uses old contents", ack_id, 90);
    rd_state(0, st);
    check("R11", "load wins state", st, 2'b01);
    ack(1'b1);
    check("R11", "loaded entry acked", ack_id, 91);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_word = '0; rd_idx = '0;
    used_cnt = CNT_W'(N_ENT); en_grp0 = 1'b1; en_grp1 = 1'b1;
    pmr = 8'hFF; run_prio = 8'hFF; ack_req = 1'b0; ack_grp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pick();
    t_state();
    t_group();
    t_pmr();
    t_run();
    t_lpi();
    t_latency();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule